// File: doc/BRIEF.md
# Quantized Box-Muller Gaussian Sample Core

This block emits one signed, approximately normal noise sample per accepted transfer. Eight linear-feedback shift registers run inside it, and each advances four recurrence steps per issued sample. Their low bits drive three things:

- a cascade of five 16-word log-radius tables;
- a 256-word quarter-wave cosine table;
- a sign bit.

The two table outputs are multiplied and floored to six fractional bits. The sign is then applied as a one's complement. All table contents are computed during elaboration, so no memory needs to be loaded.

The output is a valid/ready stream. A new sample is drawn on a clock edge where `en` is high and the output register is empty or being emptied (`out_valid` low, or `out_ready` high). While `out_valid` is high and `out_ready` is low, the sample is held unchanged and no random state moves. When `en` is low, no sample is drawn. The block is intended to feed an accumulator and scaling stage outside it.

Top module: `gauss_sample_core`

## Requirements
- R1: A synchronous reset clears `out_valid` and returns every shift register to its seed, so the sample sequence restarts from the beginning.
- R2: A load happens on an edge where `en`=1 and (`out_valid`=0 or `out_ready`=1). While `out_valid`=1 and `out_ready`=0, `out_sample` and `out_valid` hold. When no load happens and `out_ready`=1, `out_valid` falls. The random state advances only on a load.
- R3: Register lengths and feedback masks are as follows:
  - index 0: length 22, mask 0x3
  - index 1: length 21, mask 0x5
  - index 2: length 20, mask 0x9
  - index 3: length 17, mask 0x9
  - index 4: length 13, mask 0x1B
  - index 5: length 7, mask 0x3
  - index 6: length 5, mask 0x5
  - index 7: length 15, mask 0x3

  Each load applies four steps of the rule "shift left by one; if the bit shifted out was 1, XOR the mask". Each register is reset to its seed truncated to its length.
- R4: Each load uses the state as it stood before that load's steps:
  - the cosine address is {bits 3:0 of register 0, bits 3:0 of register 1};
  - level r (1..5) takes bits 3:0 of register r+1;
  - the sign is bit 0 of register 7.
- R5: Level r table word s (s=1..15) equals floor(128·sqrt(-ln((s+0.467)/16^r))). Word 0 is 0.
- R6: The address of level r is forced to 0 when any level below it has a nonzero nibble. The log term is the OR of the five table words. With all five nibbles zero, the output is 0 (sign 0) or -1 (sign 1).
- R7: Cosine word a equals floor(128·sqrt(2)·cos(π(a+0.5)/512)).
- R8: `out_sample` is a 10-bit two's-complement value. With P = floor(F·G/256), it equals P when the sign is 0 and -P-1 when the sign is 1.
- R9: `out_valid` rises on the clock edge that performs a load, i.e. one cycle after `en` is sampled high with the output free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Permits drawing a new sample |
| out_ready | input | 1 | Downstream accepts the current sample |
| out_valid | output | 1 | `out_sample` holds an unconsumed sample |
| out_sample | output | 10 | Signed noise sample, 3 integer and 6 fractional bits |

## Verification
The draining of a held sample and the loading of the next one can fall in the same edge when `out_ready` and `en` are both high while `out_valid` is set. The bench provokes this with long full-rate runs and with irregular `en`/`out_ready` patterns. It judges each cycle against a bench model of the registers, which steps only when its own load rule fires and computes the tables with real arithmetic. A second instance is seeded so that all level nibbles are zero at first. This forces the masked, all-zero log path in the same cycle as the sign application.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
  localparam int NUM_LFSR = 8;
  localparam int NIB_W    = 4;
  localparam int LVLS     = 5;
  localparam int LOG_W    = 9;   // 2.7 unsigned
  localparam int COS_W    = 8;   // 1.7 unsigned
  localparam int COS_AW   = 2 * NIB_W;
  localparam int LOG_FRAC = 7;
  localparam int COS_FRAC = 7;
  localparam int OUT_FRAC = 6;
  localparam int SHIFT    = LOG_FRAC + COS_FRAC - OUT_FRAC;
  localparam int PROD_W   = LOG_W + COS_W;
  localparam int MAG_W    = PROD_W - SHIFT;
  localparam int SAMPLE_W = MAG_W + 1;
  localparam int STEPS    = 4;
  localparam int SIGN_IDX = NUM_LFSR - 1;

  function automatic int lfsr_len(input int idx);
    case (idx)
      0: return 22;
      1: return 21;
      2: return 20;
      3: return 17;
      4: return 13;
      5: return 7;
      6: return 5;
      default: return 15;
    endcase
  endfunction

  function automatic logic [31:0] lfsr_mask(input int len);
    case (len)
      21, 5:   return 32'h5;
      20, 17:  return 32'h9;
      13:      return 32'h1B;
      default: return 32'h3;
    endcase
  endfunction

  function automatic logic [LOG_W-1:0] log_entry(input int lvl, input int s);
    real den;
    real v;
    if (s == 0) return '0;
    den = 1.0;
    for (int i = 0; i < lvl; i++) den = den * 16.0;
    v = $sqrt(-$ln((s + 0.467) / den)) * 128.0;
    return LOG_W'($rtoi(v));
  endfunction

  function automatic logic [COS_W-1:0] cos_entry(input int a);
    real v;
    v = $sqrt(2.0) * $cos(3.14159265358979323846 * (a + 0.5) / 512.0) * 128.0;
    return COS_W'($rtoi(v));
  endfunction
endpackage

// File: rtl/gsc_lfsr.sv
module gsc_lfsr #(
  parameter int          LEN   = 5,
  parameter logic [31:0] MASK  = 32'h5,
  parameter logic [31:0] SEED  = 32'h1,
  parameter int          STEPS = 4,
  parameter int          OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [OUT_W-1:0] bits_o
);
  logic [LEN-1:0] st, nxt;

  always_comb begin
    nxt = st;
    for (int i = 0; i < STEPS; i++) begin
      if (nxt[LEN-1]) nxt = {nxt[LEN-2:0], 1'b0} ^ MASK[LEN-1:0];
      else            nxt = {nxt[LEN-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      st <= SEED[LEN-1:0];
    else if (adv) st <= nxt;
  end

  assign bits_o = st[OUT_W-1:0];
endmodule

// File: rtl/gsc_log_term.sv
module gsc_log_term import gsc_pkg::*; (
  input  logic [LVLS-1:0][NIB_W-1:0] nibs,
  output logic [LOG_W-1:0]           f_val
);
  logic [LVLS-1:0]            below_nz;
  logic [LVLS-1:0][LOG_W-1:0] part;

  assign below_nz[0] = 1'b0;

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    logic [LOG_W-1:0] tbl [1 << NIB_W];
    logic [NIB_W-1:0] addr;
    for (genvar s = 0; s < (1 << NIB_W); s++) begin : g_ent
      localparam logic [LOG_W-1:0] WORD = log_entry(l + 1, s);
      assign tbl[s] = WORD;
    end
    if (l > 0) begin : g_chain
      assign below_nz[l] = below_nz[l-1] | (|nibs[l-1]);
    end
    assign addr    = below_nz[l] ? '0 : nibs[l];
    assign part[l] = tbl[addr];
  end

  always_comb begin
    f_val = '0;
    for (int l = 0; l < LVLS; l++) f_val = f_val | part[l];
  end
endmodule

// File: rtl/gsc_cos_term.sv
module gsc_cos_term import gsc_pkg::*; (
  input  logic [COS_AW-1:0] addr,
  output logic [COS_W-1:0]  g_val
);
  logic [COS_W-1:0] tbl [1 << COS_AW];

  for (genvar a = 0; a < (1 << COS_AW); a++) begin : g_ent
    localparam logic [COS_W-1:0] WORD = cos_entry(a);
    assign tbl[a] = WORD;
  end

  assign g_val = tbl[addr];
endmodule

// File: rtl/gauss_sample_core.sv
module gauss_sample_core import gsc_pkg::*; #(
  // element i seeds register i; the first listed value is element 7
  parameter logic [NUM_LFSR-1:0][31:0] SEEDS = {32'h2B, 32'h15, 32'h5A, 32'h3C1,
                                                 32'h1F07, 32'hABCD, 32'h3E21F, 32'h24F3}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_sample
);
  logic                           load;
  logic [NUM_LFSR-2:0][NIB_W-1:0] nib;
  logic                           sign_bit;
  logic [LOG_W-1:0]               f_val;
  logic [COS_W-1:0]               g_val;
  logic [PROD_W-1:0]              prod;
  logic [MAG_W-1:0]               mag;
  logic [SAMPLE_W-1:0]            next_sample;

  assign load = en && (!out_valid || out_ready);

  for (genvar i = 0; i < NUM_LFSR - 1; i++) begin : g_rng
    gsc_lfsr #(
      .LEN(lfsr_len(i)), .MASK(lfsr_mask(lfsr_len(i))), .SEED(SEEDS[i]),
      .STEPS(STEPS), .OUT_W(NIB_W)
    ) u_lfsr (.clk(clk), .rst(rst), .adv(load), .bits_o(nib[i]));
  end

  gsc_lfsr #(
    .LEN(lfsr_len(SIGN_IDX)), .MASK(lfsr_mask(lfsr_len(SIGN_IDX))),
    .SEED(SEEDS[SIGN_IDX]), .STEPS(STEPS), .OUT_W(1)
  ) u_sign (.clk(clk), .rst(rst), .adv(load), .bits_o(sign_bit));

  gsc_log_term u_log (.nibs(nib[LVLS+1:2]), .f_val(f_val));
  gsc_cos_term u_cos (.addr({nib[0], nib[1]}), .g_val(g_val));

  assign prod        = PROD_W'(f_val) * PROD_W'(g_val);
  assign mag         = MAG_W'(prod >> SHIFT);
  assign next_sample = sign_bit ? ~{1'b0, mag} : {1'b0, mag};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else if (load) begin
      out_valid  <= 1'b1;
      out_sample <= next_sample;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/gsc_checker.sv
module gsc_checker import gsc_pkg::*; (
  input logic                clk,
  input logic                rst,
  input logic                en,
  input logic                out_ready,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] out_sample
);
  localparam int MAX_MAG = (int'(log_entry(LVLS, 1)) * int'(cos_entry(0))) >>> SHIFT;

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> !out_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_sample));

  assert_drain_R2: assert property (@(posedge clk) disable iff (rst)
    !en && out_ready |=> !out_valid);

  assert_load_valid_R9: assert property (@(posedge clk) disable iff (rst)
    en && (!out_valid || out_ready) |=> out_valid);

  assert_range_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_sample) <= MAX_MAG) && ($signed(out_sample) >= -MAX_MAG - 1));
endmodule

bind gauss_sample_core gsc_checker u_chk (.*);

// File: tb/tb_gauss_sample_core.sv
module tb_gauss_sample_core;
  localparam logic [7:0][31:0] SEED_A = {32'h2B, 32'h15, 32'h5A, 32'h3C1,
                                         32'h1F07, 32'hABCD, 32'h3E21F, 32'h24F3};
  localparam logic [7:0][31:0] SEED_Z = {32'h1, 32'h10, 32'h10, 32'h10,
                                         32'h10, 32'h10, 32'h3, 32'h7};

  logic clk = 0;
  logic rst = 1, en = 0, rdy = 0;
  logic [1:0] vld;
  logic [9:0] smp [2];
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  gauss_sample_core #(.SEEDS(SEED_A)) dut (.clk(clk), .rst(rst), .en(en), .out_ready(rdy),
                                           .out_valid(vld[0]), .out_sample(smp[0]));
  gauss_sample_core #(.SEEDS(SEED_Z)) dut_z (.clk(clk), .rst(rst), .en(en), .out_ready(rdy),
                                             .out_valid(vld[1]), .out_sample(smp[1]));

  logic [31:0] ms [2][8];
  logic        ev [2];
  int          cur [2];
  int          loads_since_rst [2];

  // R3 lengths and masks, restated from the requirement
  function automatic int blen(input int i);
    int t[8] = '{22, 21, 20, 17, 13, 7, 5, 15};
    return t[i];
  endfunction
  function automatic logic [31:0] bmask(input int i);
    logic [31:0] t[8] = '{32'h3, 32'h5, 32'h9, 32'h9, 32'h1B, 32'h3, 32'h5, 32'h3};
    return t[i];
  endfunction

  // R5
  function automatic int blog(input int r, input int s);
    if (s == 0) return 0;
    return int'($floor(128.0 * $sqrt(-$ln((s + 0.467) / (16.0 ** r)))));
  endfunction
  // R7
  function automatic int bcos(input int a);
    return int'($floor(128.0 * $sqrt(2.0) * $cos(3.14159265358979323846 * (a + 0.5) / 512.0)));
  endfunction

  task automatic seed_models();
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 8; i++) begin
        ms[k][i] = ((k == 0) ? SEED_A[i] : SEED_Z[i]) & ((32'h1 << blen(i)) - 1);
      end
      ev[k] = 0;
      loads_since_rst[k] = 0;
    end
  endtask

  // R4 R6 R8: expected sample from current model state
  function automatic int model_sample(input int k);
    int f = 0, g, p, a;
    bit hit = 0;
    for (int l = 0; l < 5; l++) begin
      a = hit ? 0 : int'(ms[k][l+2][3:0]);
      if (ms[k][l+2][3:0] != 0) hit = 1;
      f = f | blog(l + 1, a);
    end
    g = bcos(int'({ms[k][0][3:0], ms[k][1][3:0]}));
    p = (f * g) / 256;
    return ms[k][7][0] ? -p - 1 : p;
  endfunction

  task automatic step_model(input int k);
    for (int i = 0; i < 8; i++) begin
      for (int n = 0; n < 4; n++) begin
        if (ms[k][i][blen(i)-1]) ms[k][i] = ((ms[k][i] << 1) ^ bmask(i)) & ((32'h1 << blen(i)) - 1);
        else                     ms[k][i] = (ms[k][i] << 1) & ((32'h1 << blen(i)) - 1);
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Called at a negedge with en/rdy as they were at the preceding posedge
  task automatic judge(input bit en_p, input bit rdy_p);
    for (int k = 0; k < 2; k++) begin
      bit ld = en_p && (!ev[k] || rdy_p);
      int act = int'($signed(smp[k]));
      if (ld) begin
        cur[k] = model_sample(k);
        step_model(k);
        ev[k] = 1;
        check(vld[k] == 1'b1, "R9 valid after load", int'(vld[k]), 1);
        check(act == cur[k], "R3 R4 R5 R6 R7 R8 sample", act, cur[k]);
        if (k == 1 && loads_since_rst[k] == 0)
          check(act == -1, "R6 all-zero levels with sign 1", act, -1);
        loads_since_rst[k]++;
      end else if (ev[k] && !rdy_p) begin
        check(vld[k] == 1'b1 && act == cur[k], "R2 hold under back-pressure", act, cur[k]);
      end else begin
        ev[k] = 0;
        check(vld[k] == 1'b0, "R2 drain without load", int'(vld[k]), 0);
      end
    end
  endtask

  task automatic run(input int n, input int mode);
    for (int c = 0; c < n; c++) begin
      bit e, r;
      case (mode)
        0: begin e = 1; r = 1; end
        1: begin e = (c % 7) != 3; r = (c % 5) != 2; end
        default: begin e = (c % 11) < 4; r = (c % 3) == 0; end
      endcase
      en = e; rdy = r;
      @(negedge clk);
      judge(e, r);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    seed_models();
    repeat (3) @(negedge clk);
    check(vld == 2'b00, "R1 reset clears valid", int'(vld), 0);
    rst = 0;
    run(600, 0);
    run(1500, 1);
    run(800, 2);
    // R1: mid-run reset restarts the sequence
    en = 1; rdy = 0; rst = 1;
    @(negedge clk);
    @(negedge clk);
    check(vld == 2'b00, "R1 reset during traffic", int'(vld), 0);
    seed_models();
    rst = 0;
    run(400, 0);
    run(300, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule